// File: doc/BRIEF.md
# Single-Bus Processor Core with Step Sequencer

This block is a minimal processor core in which every register exchanges data over one shared internal bus. The program counter, instruction register, a bank of general registers, a memory address register, a memory data register and two ALU staging registers each have a load strobe, and the bus sources also have a drive strobe. A hardwired step counter turns each instruction into a fixed series of bus transfers. The first ALU operand is parked in the Y register. The ALU input in front of Y selects either Y or the constant 4. Every ALU result lands in the Z register before it can go anywhere else.

The core fetches a 32-bit instruction and steps the program counter by 4. It then runs one of six operations: register add, subtract and XOR, a load through a register pointer, a store through a register pointer, and an add whose second operand comes from memory. Memory is reached through a request/complete handshake. The core raises a request, holds its address and write data, and stalls any step that waits for completion until the memory answers.

Top module: `sbc_core`

## Requirements
- R1: While reset is low, memReq and memWrite are 0. The first request after release is a read of byte address 0 in the first cycle after release.
- R2: Instruction fetches read consecutive byte addresses 0, 4, 8, and so on. The fetch part of every instruction takes 2 cycles plus the wait cycles.
- R3: A step that waits for completion holds until the cycle in which memDone is 1. With a memory that answers in the L-th cycle of a request, a register ALU op takes L+5 cycles, load and store take 2L+4, the memory add takes 2L+5, and an unknown opcode takes L+3.
- R4: The instruction fields are opcode in bits 31:28, destination rd in 27:24, first source rs in 23:20 and second source rt in 19:16. Opcode 0 computes rd = rs + rt, opcode 1 computes rd = rs - rt, and opcode 2 computes rd = rs XOR rt, all modulo 2^32.
- R5: Opcode 3 (load) reads the word at the byte address held in rs and writes it into rd. The data read starts 3+L cycles into the instruction.
- R6: Opcode 4 (store) writes rd to the byte address held in rs. It uses memWrite=1, and the write request starts 4+L cycles into the instruction.
- R7: Opcode 5 (memory add) computes rd = rd + word at the address held in rs. Its read starts 3+L cycles into the instruction.
- R8: Any other opcode changes no register and makes no memory access before the next fetch.
- R9: At most one source drives the internal bus in any cycle.
- R10: Once raised, memReq stays high with a stable address and write data until memDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memReq | output | 1 | Memory request pending |
| memWrite | output | 1 | Pending request is a write |
| memAddr | output | 32 | Byte address of the request |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memDone |
| memDone | input | 1 | Request completes this cycle |

## Verification
Each run uses a nine-instruction program. The program builds three pointers from its own first word and loads two operands. It applies a register ALU op, stores the result, performs a memory add and stores that too. The sweep covers add, subtract, XOR and an unknown opcode, against operand pairs that include carry out of bit 31, borrow below zero and equal high bits, under memory latencies of 1, 2 and 3. The cycle of every request is compared with the latency formulas. This separates a missing stall or an extra step from a wrong result. The stored words separate ALU function errors, operand-order errors and wrong destinations.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int SEL_W = 4;

  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_SUB   = 4'd1;
  localparam logic [3:0] OP_XOR   = 4'd2;
  localparam logic [3:0] OP_LOAD  = 4'd3;
  localparam logic [3:0] OP_STORE = 4'd4;
  localparam logic [3:0] OP_ADDM  = 4'd5;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_XOR = 2'd2} alu_op_e;

  typedef struct packed {
    logic             pcOut;
    logic             zOut;
    logic             mdrOut;
    logic             regOut;
    logic [SEL_W-1:0] regOutSel;
    logic             pcIn;
    logic             marIn;
    logic             yIn;
    logic             zIn;
    logic             irIn;
    logic             mdrIn;
    logic             regIn;
    logic [SEL_W-1:0] regInSel;
    logic             useY;
    alu_op_e          aluOp;
    logic             carryIn;
    logic             memRead;
    logic             memWrite;
    logic             waitDone;
    logic             endSeq;
  } strobes_t;
endpackage

// File: rtl/sbc_alu.sv
module sbc_alu
  import sbc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  alu_op_e           op,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] cinExt;
  assign cinExt = {{(DATA_W-1){1'b0}}, carryIn};

  always_comb begin
    case (op)
      ALU_ADD: result = opA + opB + cinExt;
      ALU_SUB: result = opA + ~opB + cinExt;
      ALU_XOR: result = opA ^ opB;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/sbc_control.sv
module sbc_control
  import sbc_pkg::*;
#(
  parameter int IR_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [IR_W-1:0] irHi,
  input  logic            memDone,
  output strobes_t        ctl
);
  localparam int STEP_W = 3;

  logic [STEP_W-1:0] step;
  logic [3:0]        opc;
  logic [SEL_W-1:0]  rd, rs, rt;

  assign opc = irHi[IR_W-1 -: 4];
  assign rd  = irHi[IR_W-5 -: SEL_W];
  assign rs  = irHi[IR_W-9 -: SEL_W];
  assign rt  = irHi[IR_W-13 -: SEL_W];

  always_comb begin
    ctl = '0;
    case (step)
      3'd0: begin
        ctl.pcOut = 1'b1; ctl.marIn = 1'b1; ctl.memRead = 1'b1;
        ctl.useY = 1'b0; ctl.aluOp = ALU_ADD; ctl.zIn = 1'b1;
      end
      3'd1: begin
        ctl.zOut = 1'b1; ctl.pcIn = 1'b1; ctl.yIn = 1'b1; ctl.waitDone = 1'b1;
      end
      3'd2: begin
        ctl.mdrOut = 1'b1; ctl.irIn = 1'b1;
      end
      default: begin
        case (opc)
          OP_ADD, OP_SUB, OP_XOR: begin
            case (step)
              3'd3: begin ctl.regOut = 1'b1; ctl.regOutSel = rs; ctl.yIn = 1'b1; end
              3'd4: begin
                ctl.regOut = 1'b1; ctl.regOutSel = rt; ctl.useY = 1'b1; ctl.zIn = 1'b1;
                ctl.aluOp = (opc == OP_SUB) ? ALU_SUB : ((opc == OP_XOR) ? ALU_XOR : ALU_ADD);
                ctl.carryIn = (opc == OP_SUB);
              end
              3'd5: begin ctl.zOut = 1'b1; ctl.regIn = 1'b1; ctl.regInSel = rd; ctl.endSeq = 1'b1; end
              default: ctl.endSeq = 1'b1;
            endcase
          end
          OP_LOAD: begin
            case (step)
              3'd3: begin ctl.regOut = 1'b1; ctl.regOutSel = rs; ctl.marIn = 1'b1; ctl.memRead = 1'b1; end
              3'd4: ctl.waitDone = 1'b1;
              3'd5: begin ctl.mdrOut = 1'b1; ctl.regIn = 1'b1; ctl.regInSel = rd; ctl.endSeq = 1'b1; end
              default: ctl.endSeq = 1'b1;
            endcase
          end
          OP_STORE: begin
            case (step)
              3'd3: begin ctl.regOut = 1'b1; ctl.regOutSel = rs; ctl.marIn = 1'b1; end
              3'd4: begin ctl.regOut = 1'b1; ctl.regOutSel = rd; ctl.mdrIn = 1'b1; ctl.memWrite = 1'b1; end
              3'd5: begin ctl.waitDone = 1'b1; ctl.endSeq = 1'b1; end
              default: ctl.endSeq = 1'b1;
            endcase
          end
          OP_ADDM: begin
            case (step)
              3'd3: begin ctl.regOut = 1'b1; ctl.regOutSel = rs; ctl.marIn = 1'b1; ctl.memRead = 1'b1; end
              3'd4: begin ctl.regOut = 1'b1; ctl.regOutSel = rd; ctl.yIn = 1'b1; ctl.waitDone = 1'b1; end
              3'd5: begin
                ctl.mdrOut = 1'b1; ctl.useY = 1'b1; ctl.aluOp = ALU_ADD; ctl.zIn = 1'b1;
              end
              3'd6: begin ctl.zOut = 1'b1; ctl.regIn = 1'b1; ctl.regInSel = rd; ctl.endSeq = 1'b1; end
              default: ctl.endSeq = 1'b1;
            endcase
          end
          default: ctl.endSeq = 1'b1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         step <= '0;
    else if (ctl.waitDone && !memDone) step <= step;
    else if (ctl.endSeq)               step <= '0;
    else                               step <= step + STEP_W'(1);
  end

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.waitDone && !memDone) |=> $stable(step));

  // R2
  seq_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.endSeq && !(ctl.waitDone && !memDone)) |=> (step == '0));
endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int IR_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          ctl,
  output logic [IR_W-1:0]   irHi,
  output logic              memReq,
  output logic              memWrite,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memDone
);
  localparam int RIDX_W = $clog2(NREG);
  localparam logic [DATA_W-1:0] FOUR = DATA_W'(4);

  logic [DATA_W-1:0] pc, mar, mdr, yReg, zReg;
  logic [DATA_W-1:0] regFile [NREG];
  logic [DATA_W-1:0] bus, aluA, aluRes;
  logic              busy, wrReg;

  always_comb begin
    bus = '0;
    if (ctl.pcOut)  bus = bus | pc;
    if (ctl.zOut)   bus = bus | zReg;
    if (ctl.mdrOut) bus = bus | mdr;
    if (ctl.regOut) bus = bus | regFile[ctl.regOutSel[RIDX_W-1:0]];
  end

  assign aluA = ctl.useY ? yReg : FOUR;

  sbc_alu #(.DATA_W(DATA_W)) alu (
    .opA(aluA), .opB(bus), .op(ctl.aluOp), .carryIn(ctl.carryIn), .result(aluRes)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0; mar <= '0; yReg <= '0; zReg <= '0; irHi <= '0;
    end else begin
      if (ctl.pcIn)  pc   <= bus;
      if (ctl.marIn) mar  <= bus;
      if (ctl.yIn)   yReg <= bus;
      if (ctl.zIn)   zReg <= aluRes;
      if (ctl.irIn)  irHi <= bus[DATA_W-1 -: IR_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
    end else if (ctl.regIn) begin
      regFile[ctl.regInSel[RIDX_W-1:0]] <= bus;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; wrReg <= 1'b0; mdr <= '0;
    end else begin
      if (ctl.memRead || ctl.memWrite) begin
        busy  <= 1'b1;
        wrReg <= ctl.memWrite;
      end else if (memDone) begin
        busy <= 1'b0;
      end
      if (ctl.mdrIn)                       mdr <= bus;
      else if (busy && memDone && !wrReg)  mdr <= memRdata;
    end
  end

  assign memReq   = busy;
  assign memWrite = wrReg;
  assign memAddr  = mar;
  assign memWdata = mdr;

  // R9
  one_driver_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl.pcOut, ctl.zOut, ctl.mdrOut, ctl.regOut}) <= 1);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memDone) |=> (busy && $stable(mar) && $stable(wrReg)));

  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrReg && !memDone) |=> $stable(mdr));

  // R2
  pc_stride_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pc != $past(pc)) |-> (pc == $past(pc) + FOUR));
endmodule

// File: rtl/sbc_core.sv
module sbc_core
  import sbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memReq,
  output logic              memWrite,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memDone
);
  localparam int IR_W = 16;

  strobes_t        ctl;
  logic [IR_W-1:0] irHi;

  sbc_control #(.IR_W(IR_W)) control (
    .clk(clk), .rstN(rstN), .irHi(irHi), .memDone(memDone), .ctl(ctl)
  );

  sbc_datapath #(.DATA_W(DATA_W), .NREG(NREG), .IR_W(IR_W)) datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .irHi(irHi),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memDone(memDone)
  );
endmodule

// File: tb/tb_sbc_core.sv
module tb_sbc_core;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq, memWrite, memDone;
  logic [31:0] memAddr, memWdata, memRdata;

  logic [31:0] mem [64];
  int lat = 1;
  int waitCnt;
  int checks = 0;
  int errors = 0;

  int          cyc, reqN;
  logic        prevReq;
  int          logCyc [32];
  logic [31:0] logAddr [32];
  logic        logWr [32];
  logic [31:0] logWd [32];

  int          expN;
  int          expCyc [16];
  logic [31:0] expAddr [16];
  logic        expWr [16];
  logic [31:0] expWd [16];
  string       expTag [16];

  always #(PERIOD/2) clk = ~clk;

  sbc_core dut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memDone(memDone)
  );

  assign memDone  = memReq && (waitCnt == lat - 1);
  assign memRdata = mem[memAddr[7:2]];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) waitCnt <= 0;
    else begin
      if (memReq) waitCnt <= memDone ? 0 : waitCnt + 1;
      else        waitCnt <= 0;
      if (memReq && memDone && memWrite) mem[memAddr[7:2]] <= memWdata;
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0; reqN = 0; prevReq = 1'b0;
    end else begin
      cyc = cyc + 1;
      if (memReq && !prevReq && reqN < 32) begin
        logCyc[reqN] = cyc; logAddr[reqN] = memAddr;
        logWr[reqN] = memWrite; logWd[reqN] = memWdata;
        reqN = reqN + 1;
      end
      prevReq = memReq;
    end
  end

  function automatic logic [31:0] enc(int op, int rd, int rs, int rt);
    return {op[3:0], rd[3:0], rs[3:0], rt[3:0], 16'h0000};
  endfunction

  task automatic addExp(int c, logic [31:0] a, logic w, logic [31:0] d, string tag);
    expCyc[expN] = c; expAddr[expN] = a; expWr[expN] = w; expWd[expN] = d; expTag[expN] = tag;
    expN++;
  endtask

  task automatic check(logic ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic runOne(int opSel, logic [31:0] a, logic [31:0] b, int l);
    logic [31:0] w0, res;
    int opc, T, L;
    bit done;
    L = l;
    rstN = 1'b0;
    lat = l;
    opc = (opSel == 3) ? 15 : opSel;
    case (opSel)
      0: res = a + b;
      1: res = a - b;
      2: res = a ^ b;
      default: res = 32'h0;
    endcase
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    w0 = enc(3, 1, 0, 0) | 32'h0000_00E0;
    mem[0] = w0;
    mem[1] = enc(0, 2, 1, 1);
    mem[2] = enc(0, 3, 2, 1);
    mem[3] = enc(3, 4, 1, 0);
    mem[4] = enc(3, 5, 2, 0);
    mem[5] = enc(opc, 6, 4, 5);
    mem[6] = enc(4, 6, 3, 0);
    mem[7] = enc(5, 4, 2, 0);
    mem[8] = enc(4, 4, 1, 0);
    mem[56] = a; mem[48] = b; mem[40] = 32'h0;

    expN = 0; T = 0;
    addExp(T+1, 32'd0, 1'b0, 32'h0, "R1");   addExp(T+L+3, 32'd0, 1'b0, 32'h0, "R5"); T += 2*L+4;
    addExp(T+1, 32'd4, 1'b0, 32'h0, "R2");   T += L+5;
    addExp(T+1, 32'd8, 1'b0, 32'h0, "R2");   T += L+5;
    addExp(T+1, 32'd12, 1'b0, 32'h0, "R2");  addExp(T+L+3, w0, 1'b0, 32'h0, "R5"); T += 2*L+4;
    addExp(T+1, 32'd16, 1'b0, 32'h0, "R2");  addExp(T+L+3, w0*2, 1'b0, 32'h0, "R5"); T += 2*L+4;
    addExp(T+1, 32'd20, 1'b0, 32'h0, "R2");  T += (opSel == 3) ? L+3 : L+5;
    addExp(T+1, 32'd24, 1'b0, 32'h0, (opSel == 3) ? "R8" : "R3"); addExp(T+L+4, w0*3, 1'b1, res, "R6"); T += 2*L+4;
    addExp(T+1, 32'd28, 1'b0, 32'h0, "R2");  addExp(T+L+3, w0*2, 1'b0, 32'h0, "R7"); T += 2*L+5;
    addExp(T+1, 32'd32, 1'b0, 32'h0, "R3");  addExp(T+L+4, w0, 1'b1, a + b, "R6");

    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!memReq && !memWrite, "R1", "reset req/write", {30'h0, memReq, memWrite}, 32'h0);
    #(PERIOD/4) rstN = 1'b1;

    done = 1'b0;
    for (int k = 0; k < 1500 && !done; k++) begin
      @(negedge clk);
      if (reqN >= 15) done = 1'b1;
    end
    if (!done) check(1'b0, "R3", "request count timeout", reqN, 32'd15);
    repeat (2*l + 6) @(negedge clk);

    for (int i = 0; i < 15; i++) begin
      check(logCyc[i] == expCyc[i], expTag[i], "request cycle", logCyc[i], expCyc[i]);
      check(logAddr[i] == expAddr[i] && logWr[i] == expWr[i], expTag[i], "request address",
            logAddr[i], expAddr[i]);
      if (expWr[i]) check(logWd[i] == expWd[i], expTag[i], "write data", logWd[i], expWd[i]);
    end
    // R4 / R8: result of the register op stored at word 40
    check(mem[40] == res, (opSel == 3) ? "R8" : "R4", "alu result", mem[40], res);
    // R7: memory add result stored at word 56
    check(mem[56] == a + b, "R7", "memory add result", mem[56], a + b);
  endtask

  initial begin
    logic [31:0] pa [5];
    logic [31:0] pb [5];
    pa[0] = 32'd5;          pb[0] = 32'd3;
    pa[1] = 32'hFFFF_FFFF;  pb[1] = 32'd1;
    pa[2] = 32'd0;          pb[2] = 32'd1;
    pa[3] = 32'h8000_0000;  pb[3] = 32'h8000_0000;
    pa[4] = 32'h1234_5678;  pb[4] = 32'h9ABC_DEF0;
    for (int l = 1; l <= 3; l++)
      for (int op = 0; op < 4; op++)
        for (int p = 0; p < 5; p++)
          runOne(op, pa[p], pb[p], l);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule